// File: doc/BRIEF.md
# Two-Wire Control Register Write Port

This block is a two-wire bus target that accepts write transfers from a bus controller and loads two small control registers. It oversamples SCL and SDA on the system clock, detects bus start and stop events, collects a 7-bit target address with a direction bit, and acknowledges by pulling SDA low when the address equals its own and the transfer is a write.

Each data byte after an accepted address goes to one of two registers, chosen by the byte's top bit. A byte whose top bit is 1 carries a 3-bit reference mode, a clock source choice and an input polarity choice. A byte whose top bit is 0 is stored, minus that bit, as a 7-bit configuration word. A cleared bit 1 in a top-bit-1 byte also returns the configuration word to its initial value. Bytes may come in any order and any number per transfer. A transfer ends with a stop or a repeated start.

Top module: `cfg_write_port`

## Requirements
- R1: While reset is held, and after it is released, ref_mode is 000, clk_ext is 0, bipolar_en is 0, cfg_word equals the CFG_INIT parameter and sda_pull is 0.
- R2: When the address byte (7 address bits, MSB first, then the direction bit) matches DEV_ADDR and the direction bit is 0, the block holds sda_pull high for the ninth clock of that byte.
- R3: When the address differs or the direction bit is 1, sda_pull stays low and the following bytes are neither acknowledged nor stored, until the next start or stop.
- R4: An accepted data byte with bit 7 = 1 loads ref_mode from bits 6:4, clk_ext from bit 3 and bipolar_en from bit 2. Bit 0 has no effect.
- R5: An accepted data byte with bit 7 = 0 loads cfg_word from bits 6:0 and leaves ref_mode, clk_ext and bipolar_en unchanged.
- R6: An accepted byte with bit 7 = 1 and bit 1 = 0 also sets cfg_word to CFG_INIT. With bit 1 = 1, cfg_word is unchanged.
- R7: Every complete data byte after an accepted address is acknowledged, for any order and count of setup and configuration bytes.
- R8: A byte cut short by a stop or a start changes no register. sda_pull is low in the cycle after a stop.
- R9: A repeated start, even inside an ignored transfer, begins a new address phase. sda_pull is low in the cycle after any start.
- R10: sda_pull rises only on a falling SCL edge after a full byte. It falls at the next falling SCL edge or at a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | Drive-low enable for the open-drain data pad |
| ref_mode | output | 3 | Reference mode field |
| clk_ext | output | 1 | Clock source choice, 1 = external |
| bipolar_en | output | 1 | Input polarity, 1 = bipolar |
| cfg_word | output | 7 | Configuration word |

## Verification
The hardest cases to reach are a byte that a start or stop interrupts partway, and a repeated start that arrives while the block is ignoring a transfer for another target. To reach them, the bench drives the bus lines bit by bit through its own open-drain model. It sends partial bytes and then ends them with a stop or a fresh start. It also aims a transfer at the wrong address and then restarts it to the right one. A behavioural model predicts every register and every acknowledge, and the bench checks them against the outputs on each settled clock.

// File: rtl/cfg_write_port.sv
module cfg_write_port #(
  parameter logic [6:0] DEV_ADDR = 7'h36,
  parameter logic [6:0] CFG_INIT = 7'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic [2:0] ref_mode,
  output logic       clk_ext,
  output logic       bipolar_en,
  output logic [6:0] cfg_word
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_DATA, S_DACK, S_SKIP} st_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  logic [7:0] shreg;
  logic [3:0] bit_cnt;
  st_t        state;

  wire scl_s = scl_sync[1];
  wire sda_s = sda_sync[1];
  wire start_seen = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_seen  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise   = scl_s & ~scl_q;
  wire scl_fall   = ~scl_s & scl_q;
  wire byte_full  = (bit_cnt == 4'd8);
  wire addr_ok    = (shreg[7:1] == DEV_ADDR) && !shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      sda_pull   <= 1'b0;
      ref_mode   <= '0;
      clk_ext    <= 1'b0;
      bipolar_en <= 1'b0;
      cfg_word   <= CFG_INIT;
    end else if (start_seen) begin
      state    <= S_ADDR;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (stop_seen) begin
      state    <= S_IDLE;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_DATA: begin
          if (scl_rise && !byte_full) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && byte_full) begin
            bit_cnt <= '0;
            if (state == S_ADDR) begin
              if (addr_ok) begin
                state    <= S_AACK;
                sda_pull <= 1'b1;
              end else begin
                state <= S_SKIP;
              end
            end else begin
              state    <= S_DACK;
              sda_pull <= 1'b1;
              if (shreg[7]) begin
                ref_mode   <= shreg[6:4];
                clk_ext    <= shreg[3];
                bipolar_en <= shreg[2];
                if (!shreg[1]) cfg_word <= CFG_INIT;
              end else begin
                cfg_word <= shreg[6:0];
              end
            end
          end
        end
        S_AACK, S_DACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            state    <= S_DATA;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

module cfg_write_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_q,
  input logic       start_seen,
  input logic       stop_seen,
  input logic       sda_pull,
  input logic [2:0] ref_mode,
  input logic       clk_ext,
  input logic       bipolar_en,
  input logic [6:0] cfg_word
);
  // R1
  rst_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!sda_pull && ref_mode == 3'd0 && !clk_ext && !bipolar_en));

  // R10
  pull_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> ($past(scl_q) && !$past(scl_s)));

  // R4
  setup_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ref_mode, clk_ext, bipolar_en}) |-> $rose(sda_pull));

  // R5
  cfg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> $rose(sda_pull));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_pull);

  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> !sda_pull);
endmodule

bind cfg_write_port cfg_write_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_q(scl_q),
  .start_seen(start_seen), .stop_seen(stop_seen), .sda_pull(sda_pull),
  .ref_mode(ref_mode), .clk_ext(clk_ext), .bipolar_en(bipolar_en),
  .cfg_word(cfg_word)
);

// File: tb/cfg_write_port_bench.sv
module cfg_write_port_bench;
  localparam logic [6:0] ADDR = 7'h36;
  localparam logic [6:0] INIT = 7'h01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, clk_ext, bipolar_en;
  logic [2:0] ref_mode;
  logic [6:0] cfg_word;
  wire sda_line = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  cfg_write_port #(.DEV_ADDR(ADDR), .CFG_INIT(INIT)) u_cfg_write_port (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .ref_mode(ref_mode), .clk_ext(clk_ext),
    .bipolar_en(bipolar_en), .cfg_word(cfg_word));

  int n_chk = 0, n_bad = 0;
  bit settle = 1'b1, done = 1'b0, m_on = 1'b0;
  logic [2:0] e_ref = 3'd0;
  logic e_ext = 1'b0, e_bip = 1'b0, e_pull = 1'b0;
  logic [6:0] e_cfg = INIT;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !settle && !done) begin
    chk("R4 ref_mode", ref_mode, e_ref);
    chk("R4 clk_ext", clk_ext, e_ext);
    chk("R4 bipolar_en", bipolar_en, e_bip);
    chk("R5 cfg_word", cfg_word, e_cfg);
    chk("R10 sda_pull", sda_pull, e_pull);
  end

  task automatic drive(input logic s, input logic d);
    settle = 1'b1;
    scl_m = s; sda_m = d;
    repeat (6) @(posedge clk);
    settle = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic bus_start();
    e_pull = 1'b0; m_on = 1'b0;
    drive(0, 1); drive(1, 1); drive(1, 0); drive(0, 0);
  endtask

  task automatic bus_stop();
    e_pull = 1'b0; m_on = 1'b0;
    drive(0, 0); drive(1, 0); drive(1, 1);
  endtask

  task automatic model_apply(input logic [7:0] v);
    if (v[7]) begin
      e_ref = v[6:4]; e_ext = v[3]; e_bip = v[2];
      if (!v[1]) e_cfg = INIT;
    end else e_cfg = v[6:0];
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      drive(0, v[i]); drive(1, v[i]);
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input bit is_addr, input string tag);
    bit ack;
    send_bits(v, 8);
    ack = is_addr ? (v[7:1] == ADDR && !v[0]) : m_on;
    if (ack) begin
      e_pull = 1'b1;
      if (!is_addr) model_apply(v);
    end
    drive(0, 1);
    drive(1, 1);
    chk(tag, !sda_line, ack);
    e_pull = 1'b0;
    drive(0, 1);
    if (is_addr) m_on = ack;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 reset sda_pull", sda_pull, 0);
    chk("R1 reset ref_mode", ref_mode, 0);
    chk("R1 reset cfg_word", cfg_word, INIT);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    settle = 1'b0;
    @(negedge clk);
    chk("R1 after reset clk_ext", clk_ext, 0);
    chk("R1 after reset bipolar_en", bipolar_en, 0);

    // R2 R4 R5: setup then configuration
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_byte(8'hDA, 0, "R7 setup ack");
    send_byte(8'h35, 0, "R7 cfg ack");
    bus_stop();
    chk("R4 ref after DA", ref_mode, 3'b101);
    chk("R5 cfg after 35", cfg_word, 7'h35);

    // R7: configuration then setup, bit 0 set (don't care)
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_byte(8'h2A, 0, "R7 cfg first ack");
    send_byte(8'hA7, 0, "R7 setup second ack");
    bus_stop();
    chk("R4 bipolar after A7", bipolar_en, 1);

    // R6: setup with bit1 = 0 resets cfg_word only
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_byte(8'hF0, 0, "R7 setup only ack");
    bus_stop();
    chk("R6 cfg reset to init", cfg_word, INIT);
    chk("R6 setup loaded", ref_mode, 3'b111);

    // R3: wrong address, then read direction
    bus_start();
    send_byte(8'h24, 1, "R3 wrong address nack");
    send_byte(8'h55, 0, "R3 ignored byte nack");
    send_byte(8'h81, 0, "R3 ignored setup nack");
    bus_stop();
    chk("R3 cfg unchanged", cfg_word, INIT);
    chk("R3 ref unchanged", ref_mode, 3'b111);
    bus_start();
    send_byte({ADDR, 1'b1}, 1, "R3 read direction nack");
    send_byte(8'h44, 0, "R3 ignored byte nack");
    bus_stop();
    chk("R3 cfg unchanged after read", cfg_word, INIT);

    // R9: repeated start out of an ignored transfer
    bus_start();
    send_byte(8'h10, 1, "R3 wrong address nack");
    send_byte(8'h66, 0, "R3 ignored byte nack");
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R9 ack after repeated start");
    send_byte(8'h11, 0, "R9 data ack after repeated start");
    bus_stop();
    chk("R9 cfg after restart", cfg_word, 7'h11);

    // R8: truncated bytes
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_bits(8'h7E, 4);
    bus_stop();
    chk("R8 cfg kept after stop cut", cfg_word, 7'h11);
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_bits(8'h8C, 7);
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R9 address ack after cut");
    send_byte(8'h5A, 0, "R7 data ack");
    send_byte(8'h9E, 0, "R7 third byte ack");
    send_byte(8'h03, 0, "R7 fourth byte ack");
    bus_stop();
    chk("R8 ref kept after start cut", ref_mode, 3'b001);
    chk("R7 last cfg", cfg_word, 7'h03);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule